// File: doc/BRIEF.md
# Peripheral Interrupt Aggregator

This block folds ten interrupt requests into a single interrupt line toward the processor. Four of the requests are per-bank summaries from GPIO banks; the other six come from other on-chip peripherals. Software sees four word registers through a small register bus: a control word, a read-only status word that mirrors the live request vector, and two storage words reserved for an interrupt timer.

The control word carries a global enable, a bit that selects how the interrupt line signals, and one enable per non-GPIO source. The GPIO bank summaries are always eligible here because each bank masks its own pins. When the global enable is set and at least one eligible request is high, the line is driven. In level mode the line stays high while that holds. In pulse mode it produces one cycle high each time the combined condition goes from false to true.

Register offsets are byte offsets inside the block's window. Bus writes take effect at the clock edge. Reads are combinational from the address.

Top module: `intagg_core`

## Requirements
- R1: After synchronous reset the control word, both timer words and the interrupt line are all zero. No interrupt is raised until software sets the global enable.
- R2: A read at offset 0x4 returns the live request vector. Bits 0 to 3 are GPIO banks A to D, bits 4 to 9 are peripheral sources 0 to 5, and the upper bits read zero.
- R3: The status word is read-only. A write to offset 0x4 changes no register, and a following read still shows the live requests.
- R4: The control word is at offset 0x0. Bit 0 is the global enable (1 = enabled), bit 1 is the signalling style, and bits 2 to 7 enable peripheral sources 0 to 5. Bits above 7 read back as zero.
- R5: While the global enable is 0, the interrupt line stays low for any request pattern.
- R6: With bit 1 at 0 (level style), the line equals the combined condition one clock after the requests are sampled.
- R7: A GPIO bank summary (status bits 0 to 3) drives the combined condition without any per-source enable.
- R8: Peripheral source k counts toward the combined condition only when control bit 2+k is 1.
- R9: With bit 1 at 1 (pulse style), the line is high for exactly one cycle after each 0-to-1 change of the combined condition. A condition that stays high, or that gains another request while already high, gives no further pulse.
- R10: The timer prescale word at offset 0x8 and the timer set word at offset 0xC are plain 16-bit storage that reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| addr_i | input | 4 | Byte offset of the register access |
| wr_en_i | input | 1 | Write strobe, committed at the rising edge |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Combinational read data for addr_i |
| req_i | input | 10 | Request vector: banks in bits 0-3, peripherals in bits 4-9 |
| irq_o | output | 1 | Interrupt line toward the processor |

## Verification
Two things can meet in one cycle: a control write that changes the enables or the style, and a change on the request vector. Both alter the combined condition that the output stage registers. The bench sweeps every request pattern against several enable sets, and every enable set against each single source. It then runs a pulse-style sequence in which a second source joins an already high condition, and one in which a disabled source toggles. Each observation is judged by recomputing eligibility and edge state arithmetically from the control value the bench wrote.

// File: rtl/intagg_pkg.sv
package intagg_pkg;
  // Byte offsets within the register window
  localparam int OFS_CTRL  = 'h0;
  localparam int OFS_STAT  = 'h4;
  localparam int OFS_PRESC = 'h8;
  localparam int OFS_TSET  = 'hC;

  // Control word bit positions
  localparam int CTRL_GIE_BIT  = 0;
  localparam int CTRL_EDGE_BIT = 1;
  localparam int CTRL_EN_LSB   = 2;

  // Whether source idx may contribute, given the control word.
  // Bank summaries are always eligible; peripherals use their enable bit.
  function automatic logic src_eligible(input int idx, input int n_bank,
                                        input logic [31:0] ctrl);
    logic ok;
    if (idx < n_bank) ok = 1'b1;
    else              ok = ctrl[CTRL_EN_LSB + idx - n_bank];
    return ok;
  endfunction
endpackage

// File: rtl/intagg_regs.sv
module intagg_regs
  import intagg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  parameter int N_SRC  = 10,
  parameter int CTRL_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [N_SRC-1:0]  req_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [CTRL_W-1:0] ctrl_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] presc_q;
  logic [DATA_W-1:0] tset_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ctrl_q  <= '0;
      presc_q <= '0;
      tset_q  <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        ADDR_W'(OFS_CTRL):  ctrl_q  <= wr_data_i[CTRL_W-1:0];
        ADDR_W'(OFS_PRESC): presc_q <= wr_data_i;
        ADDR_W'(OFS_TSET):  tset_q  <= wr_data_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (addr_i)
      ADDR_W'(OFS_CTRL):  rd_data_o[CTRL_W-1:0] = ctrl_q;
      ADDR_W'(OFS_STAT):  rd_data_o[N_SRC-1:0]  = req_i;
      ADDR_W'(OFS_PRESC): rd_data_o             = presc_q;
      ADDR_W'(OFS_TSET):  rd_data_o             = tset_q;
      default:            rd_data_o             = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/intagg_combine.sv
module intagg_combine
  import intagg_pkg::*;
#(
  parameter int N_BANK   = 4,
  parameter int N_PERIPH = 6,
  parameter int CTRL_W   = 8,
  localparam int N_SRC   = N_BANK + N_PERIPH
) (
  input  logic [N_SRC-1:0]  req_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic [N_SRC-1:0]  hit_o,
  output logic              any_hit_o
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign hit_o[g] = req_i[g] & src_eligible(g, N_BANK, 32'(ctrl_i));
  end

  assign any_hit_o = ctrl_i[CTRL_GIE_BIT] & (|hit_o);
endmodule

// File: rtl/intagg_signal.sv
module intagg_signal (
  input  logic clk_i,
  input  logic rst_i,
  input  logic any_hit_i,
  input  logic edge_mode_i,
  output logic prev_hit_o,
  output logic irq_o
);
  logic prev_q;
  logic irq_q;
  logic rise;

  assign rise = any_hit_i & ~prev_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      prev_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= any_hit_i;
      irq_q  <= edge_mode_i ? rise : any_hit_i;
    end
  end

  assign prev_hit_o = prev_q;
  assign irq_o      = irq_q;
endmodule

// File: rtl/intagg_core.sv
module intagg_core
  import intagg_pkg::*;
#(
  parameter int N_BANK   = 4,
  parameter int N_PERIPH = 6,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 4,
  localparam int N_SRC   = N_BANK + N_PERIPH,
  localparam int CTRL_W  = CTRL_EN_LSB + N_PERIPH
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [N_SRC-1:0]  req_i,
  output logic              irq_o
);
  // Named internal events, visible to the bound checker
  logic [CTRL_W-1:0] ctrl_q;
  logic [N_SRC-1:0]  hit_vec;
  logic              any_hit;
  logic              prev_hit;

  intagg_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_SRC(N_SRC), .CTRL_W(CTRL_W)
  ) regs_i (
    .clk_i(clk_i), .rst_i(rst_i), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .req_i(req_i), .rd_data_o(rd_data_o),
    .ctrl_o(ctrl_q)
  );

  intagg_combine #(
    .N_BANK(N_BANK), .N_PERIPH(N_PERIPH), .CTRL_W(CTRL_W)
  ) comb_i (
    .req_i(req_i), .ctrl_i(ctrl_q), .hit_o(hit_vec), .any_hit_o(any_hit)
  );

  intagg_signal sig_i (
    .clk_i(clk_i), .rst_i(rst_i), .any_hit_i(any_hit),
    .edge_mode_i(ctrl_q[CTRL_EDGE_BIT]), .prev_hit_o(prev_hit),
    .irq_o(irq_o)
  );
endmodule

// File: rtl/intagg_checker.sv
module intagg_checker
  import intagg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  parameter int N_SRC  = 10,
  parameter int CTRL_W = 8
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [N_SRC-1:0]  req_i,
  input logic              irq_o,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic              any_hit,
  input logic              prev_hit
);
  logic gie, edge_m;
  assign gie    = ctrl_q[CTRL_GIE_BIT];
  assign edge_m = ctrl_q[CTRL_EDGE_BIT];

  assert_reset_clears_R1: assert property (@(posedge clk_i)
    rst_i |=> (ctrl_q == '0 && !irq_o));

  assert_status_live_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (addr_i == ADDR_W'(OFS_STAT)) |-> (rd_data_o == DATA_W'(req_i)));

  assert_gie_off_quiet_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    !gie |=> !irq_o);

  assert_level_high_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (!edge_m && any_hit) |=> irq_o);

  assert_level_low_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (!edge_m && !any_hit) |=> !irq_o);

  assert_pulse_rise_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    (edge_m && any_hit && !prev_hit) |=> irq_o);

  assert_pulse_single_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    (edge_m && prev_hit) |=> !irq_o);
endmodule

bind intagg_core intagg_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_SRC(N_SRC), .CTRL_W(CTRL_W)
) chk_i (
  .clk_i(clk_i), .rst_i(rst_i), .addr_i(addr_i), .rd_data_o(rd_data_o),
  .req_i(req_i), .irq_o(irq_o), .ctrl_q(ctrl_q), .any_hit(any_hit),
  .prev_hit(prev_hit)
);

// File: tb/intagg_core_tb_top.sv
`timescale 1ns/1ps
module intagg_core_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [9:0]  req = '0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  intagg_core dut_i (
    .clk_i(clk), .rst_i(rst), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wdata), .rd_data_o(rdata), .req_i(req), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  // Bench model of the combined condition
  function automatic logic model_hit(input logic [7:0] c, input logic [9:0] r);
    int cnt;
    cnt = 0;
    for (int i = 0; i < 4; i++) cnt += int'(r[i]);
    for (int k = 0; k < 6; k++) cnt += int'(r[4+k] && c[2+k]);
    return c[0] && (cnt > 0);
  endfunction

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  c;
    logic [7:0]  pens [3];
    pens[0] = 8'h00; pens[1] = 8'h3F; pens[2] = 8'h15;

    req = 10'h3FF;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state, all requests high but nothing enabled
    rd(4'h0, v); check("R1 ctrl", v, 16'h0);
    rd(4'h8, v); check("R1 presc", v, 16'h0);
    rd(4'hC, v); check("R1 tset", v, 16'h0);
    check("R1 irq", 16'(irq), 16'h0);

    // R2: status mirrors every request pattern
    for (int r = 0; r < 1024; r++) begin
      req = 10'(r);
      rd(4'h4, v);
      check("R2 status", v, 16'(r));
    end

    // R4: control layout and upper bits
    wr(4'h0, 16'hFFFF);
    rd(4'h0, v); check("R4 ctrl readback", v, 16'h00FF);
    wr(4'h0, 16'h0000);
    rd(4'h0, v); check("R4 ctrl clear", v, 16'h0000);

    // R10: timer storage words
    wr(4'h8, 16'hA5C3);
    wr(4'hC, 16'h1234);
    rd(4'h8, v); check("R10 presc", v, 16'hA5C3);
    rd(4'hC, v); check("R10 tset", v, 16'h1234);

    // R3: writing status changes nothing
    wr(4'h0, 16'h0055);
    req = 10'h2AA;
    wr(4'h4, 16'hFFFF);
    rd(4'h4, v); check("R3 status after write", v, 16'h02AA);
    rd(4'h0, v); check("R3 ctrl untouched", v, 16'h0055);
    rd(4'h8, v); check("R3 presc untouched", v, 16'hA5C3);

    // R5: global enable off, all peripherals enabled, level style
    wr(4'h0, 16'h00FC);
    @(negedge clk);
    for (int r = 0; r < 1024; r += 7) begin
      req = 10'(r);
      @(negedge clk);
      check("R5 gie off", 16'(irq), 16'h0);
    end

    // R6/R7/R8: level style, full request sweep for several enable sets
    foreach (pens[p]) begin
      c = {pens[p][5:0], 2'b01};
      wr(4'h0, 16'(c));
      for (int r = 0; r < 1024; r++) begin
        req = 10'(r);
        @(negedge clk);
        check("R6 level sweep", 16'(irq), 16'(model_hit(c, 10'(r))));
      end
    end

    // R7/R8: each single source against every enable set
    for (int pe = 0; pe < 64; pe++) begin
      c = {6'(pe), 2'b01};
      wr(4'h0, 16'(c));
      for (int s = 0; s < 10; s++) begin
        req = 10'(1 << s);
        @(negedge clk);
        if (s < 4) check("R7 bank always eligible", 16'(irq), 16'h1);
        else       check("R8 peripheral enable", 16'(irq), 16'(pe[s-4]));
      end
    end

    // R9: pulse style, only banks eligible
    req = '0;
    wr(4'h0, 16'h0003);
    @(negedge clk);
    check("R9 idle", 16'(irq), 16'h0);
    req = 10'h001; @(negedge clk); check("R9 first rise", 16'(irq), 16'h1);
    @(negedge clk); check("R9 held no repeat", 16'(irq), 16'h0);
    req = 10'h003; @(negedge clk); check("R9 joiner no pulse", 16'(irq), 16'h0);
    req = 10'h010; @(negedge clk); check("R9 disabled source only", 16'(irq), 16'h0);
    req = 10'h030; @(negedge clk); check("R9 disabled toggle", 16'(irq), 16'h0);
    req = 10'h004; @(negedge clk); check("R9 second rise", 16'(irq), 16'h1);
    @(negedge clk); check("R9 one cycle", 16'(irq), 16'h0);
    // peripheral 0 enabled in pulse style
    req = '0;
    wr(4'h0, 16'h0007);
    @(negedge clk);
    req = 10'h010; @(negedge clk); check("R9 peripheral rise", 16'(irq), 16'h1);
    @(negedge clk); check("R9 peripheral held", 16'(irq), 16'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule